// File: doc/BRIEF.md
# Parallel Display Write Bus Engine

This block converts single write requests into timed write cycles on an 8080-style parallel bus that drives a display controller. Each request carries one data word and a flag that says whether the word is a command or a parameter/pixel word. The engine places the word on a 16-bit data bus, drives the data/command select line from the flag, and generates an active-low chip-select and an active-low write strobe inside a window whose length is set in clock periods.

The transfer length, the first and last active cycles of chip-select, and the first and last active cycles of the write strobe are all inputs. They are captured when a request is accepted, so software may change them between transfers without disturbing a transfer in flight. A common setting is a 9-cycle transfer with chip-select active in cycles 1 to 8 and the strobe in cycles 2 to 5. A shortened setting for fast pixel clocks uses 7 cycles with chip-select in cycles 1 to 6. A hold option keeps chip-select asserted for the whole transfer, so that back-to-back transfers never release it. With the option off, chip-select is released between transfers.

Requests use a valid/ready handshake. Ready rises in the final cycle of a transfer, so a waiting request starts in the very next cycle. The bus outputs come straight from flops.

Top module: `mcu_bus_writer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chip-select and write strobe are high (inactive) and ready is high.
- R2: An accepted request occupies exactly `cfg_total` clock cycles, numbered 0 to `cfg_total`-1. Cycle 0 is the first cycle after the accepting edge. Ready is low in every cycle except the last, and the cycle after acceptance is never a ready cycle.
- R3: With `cfg_hold` = 0, chip-select is low in exactly the cycles `cfg_cs_first` to `cfg_cs_last` (inclusive) of the transfer, and high in all other cycles.
- R4: The write strobe is low in exactly the cycles `cfg_wr_first` to `cfg_wr_last` (inclusive), and never while chip-select is high.
- R5: From cycle 0 until the next acceptance, the data bus carries the accepted word and the DC line carries the flag (0 = command, 1 = data). Neither changes at any other time.
- R6: A request that is valid during the last cycle of a transfer is accepted at that cycle's closing edge. Its cycle 0 follows with no idle cycle in between.
- R7: With `cfg_hold` = 1, chip-select is low in every cycle of the transfer, so it stays low across back-to-back transfers.
- R8: Timing inputs are captured at acceptance. Changing them during a transfer has no effect on that transfer's waveform.
- R9: When no transfer is running, chip-select and write strobe are high and ready is high.
- R10: Settings must satisfy cs_first ≤ wr_first < wr_last ≤ cs_last < total. Every setting applied to the block is checked against this order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_is_data | input | 1 | 0 = command word, 1 = data word |
| req_word | input | DATA_W | Word to write |
| cfg_total | input | CNT_W | Transfer length in clock cycles |
| cfg_cs_first | input | CNT_W | First cycle with chip-select active |
| cfg_cs_last | input | CNT_W | Last cycle with chip-select active |
| cfg_wr_first | input | CNT_W | First cycle with write strobe active |
| cfg_wr_last | input | CNT_W | Last cycle with write strobe active |
| cfg_hold | input | 1 | Keep chip-select active for the whole transfer |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dc | output | 1 | Data/command select |
| bus_data | output | DATA_W | Parallel data bus |

## Verification
The assertions watch four properties on every cycle:
- the strobe is never active while chip-select is inactive;
- the bus is idle after any ready cycle without a request;
- ready drops right after an acceptance;
- the data bus and DC line change only after an acceptance and then carry the accepted values.

Only the bench scenarios show the exact placement of each edge inside the window for several timings, including the default and reduced settings and the tightest legal windows. The bench scenarios also cover the cycle count between back-to-back transfers, chip-select staying low across a boundary in hold mode, and the capture of timing inputs at acceptance while they change mid-transfer.

// File: rtl/mcu_bus_pkg.sv
package mcu_bus_pkg;

   localparam int unsigned IDX_W = 16;

   // inclusive window test on a cycle index
   function automatic logic win_hit(input logic [IDX_W-1:0] idx,
                                    input logic [IDX_W-1:0] lo,
                                    input logic [IDX_W-1:0] hi);
      return (idx >= lo) && (idx <= hi);
   endfunction

endpackage

// File: rtl/mcu_bus_seq.sv
module mcu_bus_seq #(
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_is_data,
   input  logic [DATA_W-1:0] req_word,
   input  logic [CNT_W-1:0]  cfg_total,
   input  logic [CNT_W-1:0]  cfg_cs_first,
   input  logic [CNT_W-1:0]  cfg_cs_last,
   input  logic [CNT_W-1:0]  cfg_wr_first,
   input  logic [CNT_W-1:0]  cfg_wr_last,
   input  logic              cfg_hold,
   output logic              nxt_busy,
   output logic [CNT_W-1:0]  nxt_idx,
   output logic [CNT_W-1:0]  nxt_cs_first,
   output logic [CNT_W-1:0]  nxt_cs_last,
   output logic [CNT_W-1:0]  nxt_wr_first,
   output logic [CNT_W-1:0]  nxt_wr_last,
   output logic              nxt_hold,
   output logic              bus_dc,
   output logic [DATA_W-1:0] bus_data
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             busy_q;
   logic [CNT_W-1:0] idx_q, tot_q, csf_q, csl_q, wrf_q, wrl_q;
   logic             hold_q;
   logic [CNT_W-1:0] nxt_tot;
   logic             last, accept;

   assign last      = busy_q && (idx_q == tot_q - ONE);
   assign req_ready = !busy_q || last;
   assign accept    = req_valid && req_ready;

   always_comb begin
      nxt_busy     = busy_q;
      nxt_idx      = idx_q;
      nxt_tot      = tot_q;
      nxt_cs_first = csf_q;
      nxt_cs_last  = csl_q;
      nxt_wr_first = wrf_q;
      nxt_wr_last  = wrl_q;
      nxt_hold     = hold_q;
      if (accept) begin
         nxt_busy     = 1'b1;
         nxt_idx      = '0;
         nxt_tot      = cfg_total;
         nxt_cs_first = cfg_cs_first;
         nxt_cs_last  = cfg_cs_last;
         nxt_wr_first = cfg_wr_first;
         nxt_wr_last  = cfg_wr_last;
         nxt_hold     = cfg_hold;
      end else if (last) begin
         nxt_busy = 1'b0;
      end else if (busy_q) begin
         nxt_idx = idx_q + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         tot_q  <= '0;
         csf_q  <= '0;
         csl_q  <= '0;
         wrf_q  <= '0;
         wrl_q  <= '0;
         hold_q <= 1'b0;
      end else begin
         busy_q <= nxt_busy;
         idx_q  <= nxt_idx;
         tot_q  <= nxt_tot;
         csf_q  <= nxt_cs_first;
         csl_q  <= nxt_cs_last;
         wrf_q  <= nxt_wr_first;
         wrl_q  <= nxt_wr_last;
         hold_q <= nxt_hold;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_dc   <= 1'b0;
         bus_data <= '0;
      end else if (accept) begin
         bus_dc   <= req_is_data;
         bus_data <= req_word;
      end
   end

   // R5: bus contents follow an acceptance and only an acceptance
   a_r5_word_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (bus_data == $past(req_word)) && (bus_dc == $past(req_is_data)));
   a_r5_no_stray_change: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> $stable(bus_data) && $stable(bus_dc));
   // R2: the cycle after an acceptance is never the final one
   a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/mcu_bus_strobe.sv
module mcu_bus_strobe #(
   parameter int unsigned CNT_W      = 4,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nxt_busy,
   input  logic [CNT_W-1:0] nxt_idx,
   input  logic [CNT_W-1:0] win_lo,
   input  logic [CNT_W-1:0] win_hi,
   input  logic             force_on,
   output logic             pin
);
   import mcu_bus_pkg::*;

   logic on_d;
   assign on_d = nxt_busy && (force_on ||
                 win_hit(IDX_W'(nxt_idx), IDX_W'(win_lo), IDX_W'(win_hi)));

   generate
      if (ACTIVE_LOW) begin : g_low
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin <= 1'b1;
            else        pin <= !on_d;
         end
      end else begin : g_high
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin <= 1'b0;
            else        pin <= on_d;
         end
      end
   endgenerate

endmodule

// File: rtl/mcu_bus_writer.sv
module mcu_bus_writer #(
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_is_data,
   input  logic [DATA_W-1:0] req_word,
   input  logic [CNT_W-1:0]  cfg_total,
   input  logic [CNT_W-1:0]  cfg_cs_first,
   input  logic [CNT_W-1:0]  cfg_cs_last,
   input  logic [CNT_W-1:0]  cfg_wr_first,
   input  logic [CNT_W-1:0]  cfg_wr_last,
   input  logic              cfg_hold,
   output logic              bus_cs_n,
   output logic              bus_wr_n,
   output logic              bus_dc,
   output logic [DATA_W-1:0] bus_data
);
   generate
      if (CNT_W < 2 || CNT_W > mcu_bus_pkg::IDX_W) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and 16");
      end
      if (DATA_W == 0 || (DATA_W % 8) != 0) begin : g_bad_data
         $error("DATA_W must be a non-zero multiple of 8");
      end
   endgenerate

   logic             nxt_busy, nxt_hold;
   logic [CNT_W-1:0] nxt_idx, nxt_csf, nxt_csl, nxt_wrf, nxt_wrl;

   mcu_bus_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_is_data(req_is_data), .req_word(req_word),
      .cfg_total(cfg_total), .cfg_cs_first(cfg_cs_first), .cfg_cs_last(cfg_cs_last),
      .cfg_wr_first(cfg_wr_first), .cfg_wr_last(cfg_wr_last), .cfg_hold(cfg_hold),
      .nxt_busy(nxt_busy), .nxt_idx(nxt_idx),
      .nxt_cs_first(nxt_csf), .nxt_cs_last(nxt_csl),
      .nxt_wr_first(nxt_wrf), .nxt_wr_last(nxt_wrl), .nxt_hold(nxt_hold),
      .bus_dc(bus_dc), .bus_data(bus_data)
   );

   mcu_bus_strobe #(.CNT_W(CNT_W), .ACTIVE_LOW(1'b1)) u_cs (
      .clk(clk), .rst_n(rst_n), .nxt_busy(nxt_busy), .nxt_idx(nxt_idx),
      .win_lo(nxt_csf), .win_hi(nxt_csl), .force_on(nxt_hold), .pin(bus_cs_n)
   );

   mcu_bus_strobe #(.CNT_W(CNT_W), .ACTIVE_LOW(1'b1)) u_wr (
      .clk(clk), .rst_n(rst_n), .nxt_busy(nxt_busy), .nxt_idx(nxt_idx),
      .win_lo(nxt_wrf), .win_hi(nxt_wrl), .force_on(1'b0), .pin(bus_wr_n)
   );

   // R4: write strobe only inside chip-select
   a_r4_wr_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> !bus_cs_n);
   // R9: a ready cycle with no request leaves the bus idle
   a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid) |=> (bus_cs_n && bus_wr_n));

endmodule

// File: tb/mcu_bus_writer_bench.sv
module mcu_bus_writer_bench;
   typedef struct packed {
      logic [3:0]  tot, csf, csl, wrf, wrl;
      logic        hold, dc;
      logic [15:0] word;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{4'd9,  4'd1, 4'd8,  4'd2, 4'd5, 1'b0, 1'b1, 16'hA5C3},
      '{4'd7,  4'd1, 4'd6,  4'd2, 4'd5, 1'b0, 1'b0, 16'h00E0},
      '{4'd4,  4'd0, 4'd3,  4'd1, 4'd2, 1'b0, 1'b1, 16'h1234},
      '{4'd3,  4'd0, 4'd2,  4'd0, 4'd2, 1'b0, 1'b1, 16'hFFFF},
      '{4'd15, 4'd3, 4'd12, 4'd5, 4'd9, 1'b0, 1'b0, 16'h0F0F},
      '{4'd9,  4'd1, 4'd8,  4'd2, 4'd5, 1'b1, 1'b1, 16'h5555},
      '{4'd2,  4'd0, 4'd1,  4'd0, 4'd1, 1'b0, 1'b1, 16'h8001},
      '{4'd6,  4'd2, 4'd4,  4'd2, 4'd4, 1'b0, 1'b0, 16'h7E7E}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_is_data = 1'b0;
   logic [15:0] req_word = '0;
   logic [3:0] cfg_total = 4'd9, cfg_cs_first = 4'd1, cfg_cs_last = 4'd8;
   logic [3:0] cfg_wr_first = 4'd2, cfg_wr_last = 4'd5;
   logic cfg_hold = 1'b0;
   logic req_ready, bus_cs_n, bus_wr_n, bus_dc;
   logic [15:0] bus_data;

   int checks = 0, bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mcu_bus_writer u_mcu_bus_writer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_is_data(req_is_data), .req_word(req_word),
      .cfg_total(cfg_total), .cfg_cs_first(cfg_cs_first), .cfg_cs_last(cfg_cs_last),
      .cfg_wr_first(cfg_wr_first), .cfg_wr_last(cfg_wr_last), .cfg_hold(cfg_hold),
      .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_dc(bus_dc), .bus_data(bus_data)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit order_ok(input vec_t v);
      return (v.csf <= v.wrf) && (v.wrf < v.wrl) && (v.wrl <= v.csl) && (v.csl < v.tot);
   endfunction

   task automatic apply_cfg(input vec_t v);
      cfg_total = v.tot; cfg_cs_first = v.csf; cfg_cs_last = v.csl;
      cfg_wr_first = v.wrf; cfg_wr_last = v.wrl; cfg_hold = v.hold;
   endtask

   // one transfer from idle; optionally swap timing inputs after cycle 0
   task automatic run_vec(input vec_t v, input vec_t alt, input bit swap, input string req);
      int cs_err = 0, wr_err = 0, rdy_err = 0;
      check(order_ok(v), "R10", "setting order", 0, 1);
      @(negedge clk);
      apply_cfg(v);
      req_word = v.word; req_is_data = v.dc; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(bus_data == v.word && bus_dc == v.dc, "R5", "word/dc at cycle 0",
            int'({bus_dc, bus_data}), int'({v.dc, v.word}));
      if (swap) apply_cfg(alt);
      for (int k = 0; k < int'(v.tot); k++) begin
         if (k > 0) @(negedge clk);
         if (bus_cs_n != !(v.hold || (k >= int'(v.csf) && k <= int'(v.csl)))) cs_err++;
         if (bus_wr_n != !(k >= int'(v.wrf) && k <= int'(v.wrl))) wr_err++;
         if (req_ready != (k == int'(v.tot) - 1)) rdy_err++;
      end
      check(cs_err == 0, v.hold ? "R7" : "R3", {req, " cs window"}, cs_err, 0);
      check(wr_err == 0, "R4", {req, " wr window"}, wr_err, 0);
      check(rdy_err == 0, "R2", {req, " ready/length"}, rdy_err, 0);
      @(negedge clk);
      check(bus_cs_n && bus_wr_n && req_ready, "R9", "idle after transfer",
            int'({bus_cs_n, bus_wr_n, req_ready}), 7);
      check(bus_data == v.word, "R5", "word held while idle", int'(bus_data), int'(v.word));
      apply_cfg(VECS[0]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         check(1'b0, "R2", "watchdog expired", 0, 1);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      int gap, cs_hi;
      // R1: reset state
      repeat (3) @(negedge clk);
      check(bus_cs_n && bus_wr_n && req_ready, "R1", "outputs during reset",
            int'({bus_cs_n, bus_wr_n, req_ready}), 7);
      rst_n = 1'b1;
      @(negedge clk);
      check(bus_cs_n && bus_wr_n && req_ready, "R1", "outputs after reset",
            int'({bus_cs_n, bus_wr_n, req_ready}), 7);

      // table walk: R2 R3 R4 R5 R7 R9 R10
      for (int i = 0; i < NV; i++) run_vec(VECS[i], VECS[i], 1'b0, "table");

      // R8: timing inputs changed mid-transfer are ignored
      run_vec(VECS[0], VECS[2], 1'b1, "R8 cfg swap");

      // R6: back-to-back, next word appears exactly tot cycles after cycle 0
      check(order_ok(VECS[1]), "R10", "setting order b2b", 0, 1);
      @(negedge clk);
      apply_cfg(VECS[1]);
      req_word = 16'h1111; req_is_data = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_word = 16'h2222; req_is_data = 1'b1;
      gap = 0;
      while (bus_data != 16'h2222 && gap < 40) begin
         @(negedge clk);
         gap++;
      end
      req_valid = 1'b0;
      check(gap == 7, "R6", "cycles to next word", gap, 7);
      check(bus_dc == 1'b1 && bus_cs_n, "R6", "second transfer cycle 0",
            int'({bus_dc, bus_cs_n}), 3);
      repeat (8) @(negedge clk);

      // R7: hold keeps CS low across back-to-back transfers
      check(order_ok(VECS[5]), "R10", "setting order hold", 0, 1);
      apply_cfg(VECS[5]);
      req_word = 16'h3333; req_is_data = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_word = 16'h4444;
      cs_hi = 0;
      for (int k = 0; k < 18; k++) begin
         if (k > 0) @(negedge clk);
         if (k == 9) req_valid = 1'b0;
         if (bus_cs_n) cs_hi++;
      end
      check(cs_hi == 0, "R7", "cs high cycles in hold burst", cs_hi, 0);
      @(negedge clk);
      check(bus_cs_n && bus_data == 16'h4444, "R9", "idle after hold burst",
            int'(bus_cs_n), 1);
      apply_cfg(VECS[0]);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule